// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags

This block buffers the characters that a serial receiver assembles, one entry per character. Each entry holds the eight data bits together with three error indications (parity error, framing error, break) that the receive shift register produced for that character, so the status the host sees always belongs to the character it is about to read. The oldest entry is always visible on the outputs: its data byte, and its three tags arranged as the line-status bits 4 down to 2.

A control input switches between queued operation (up to 64 characters) and single-character operation, where the block acts as one holding register. In queued operation a two-bit selector picks the fill level at which the receive-data interrupt rises. The fill count is driven every cycle so that a neighbouring flow-control block can throttle the remote sender. A write that finds no room is discarded and latches a sticky overrun flag, which a line-status read clears.

Top module: `rx_tag_fifo`

## Requirements
- R1: During and right after synchronous reset, fill_count is 0 and data_ready, rx_irq and overrun are 0, even if wr_valid is high in the reset cycles.
- R2: Characters leave in the order they were written; head_data shows the oldest stored character whenever fill_count is non-zero.
- R3: The tags travel with their character: lsr_tags[0] (line-status bit 2) is the parity error, lsr_tags[1] (bit 3) the framing error, lsr_tags[2] (bit 4) the break indication, all of the head entry.
- R4: A write alone raises fill_count by one, a pop alone lowers it by one, and a write with a pop in the same cycle leaves it unchanged; a pop while empty is ignored, so a write plus pop on an empty queue stores the character and gives fill_count 1.
- R5: data_ready is 1 exactly when fill_count is non-zero.
- R6: In queued mode (fifo_en = 1), rx_irq is 1 exactly when fill_count is at or above the selected level: trig_sel 0 gives 8, 1 gives 16, 2 gives 56, 3 gives 60; the selector acts combinationally.
- R7: A write with no pop while the queue holds 64 entries is dropped: fill_count stays 64, the head character is unchanged and overrun becomes 1. A write together with a pop at 64 entries is accepted and does not set overrun.
- R8: overrun stays 1 until a cycle with lsr_rd = 1 clears it; if a dropping write and lsr_rd fall in the same cycle, overrun ends at 1.
- R9: In single-character mode (fifo_en = 0) the capacity is one entry, rx_irq equals data_ready regardless of trig_sel, and a second write while the entry is held is dropped and sets overrun.
- R10: Any change of fifo_en empties the queue at the next clock edge; writes and pops in that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | 1 = queued mode, 0 = single holding register |
| trig_sel | input | 2 | Interrupt fill-level selector |
| wr_valid | input | 1 | Store one received character this cycle |
| wr_data | input | 8 | Received character |
| wr_parity_err | input | 1 | Parity error of the written character |
| wr_frame_err | input | 1 | Framing error of the written character |
| wr_break | input | 1 | Break indication of the written character |
| rd_pop | input | 1 | Remove the head entry |
| lsr_rd | input | 1 | Line-status read; clears overrun |
| head_data | output | 8 | Data byte of the head entry |
| lsr_tags | output | 3 | Head entry tags as line-status bits 4:2 |
| data_ready | output | 1 | Queue non-empty |
| rx_irq | output | 1 | Receive-data interrupt |
| overrun | output | 1 | Sticky overrun flag |
| fill_count | output | 7 | Number of stored entries |

## Verification
The two functions that meet in one cycle are storing a character and removing the head: the bench drives wr_valid and rd_pop together on an empty queue, on a partly filled queue and on a full queue, and judges each case by fill_count, head_data and overrun one edge later. A second collision, a dropping write against an overrun-clearing status read, is provoked in the same way and must leave overrun set.

// File: rtl/rxq_pkg.sv
// Package rxq_pkg
// Shared widths and the entry type of the receive queue.
// Assumes one character is eight data bits with three error tags.
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int TAG_W  = 3;

    // One stored character: tags[0] parity, tags[1] framing, tags[2] break
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tags;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// Module rxq_store
// Register-array storage for the receive queue: one write port addressed
// by the write pointer, one combinational read port at the read pointer.
// Assumes the controller never asserts push when no slot is free.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             push,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    input  rxq_entry_t       wr_entry,
    output rxq_entry_t       head_entry
);
    rxq_entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Capture the incoming entry into this slot when it is addressed
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g)) begin
                slots[g] <= wr_entry;
            end
        end
    end

    // Present the oldest entry
    assign head_entry = slots[rd_ptr];
endmodule

// File: rtl/rxq_ctrl.sv
// Module rxq_ctrl
// Pointer, fill-count and overrun control of the receive queue.
// Capacity is DEPTH in queued mode and one entry otherwise; a change of
// mode flushes the queue. Assumes synchronous active-low reset.
module rxq_ctrl #(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             wr_valid,
    input  logic             rd_pop,
    input  logic             lsr_rd,
    output logic             push,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             nonempty,
    output logic             overrun
);
    localparam logic [CNT_W-1:0] CAP_Q   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_ONE = CNT_W'(1);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(DEPTH - 1);

    logic             en_q;
    logic             flush;
    logic             full;
    logic             pop;
    logic             drop;
    logic [CNT_W-1:0] count_nxt;

    // Decode this cycle's queue operations
    always_comb begin
        flush     = (fifo_en != en_q);
        full      = (count >= (fifo_en ? CAP_Q : CAP_ONE));
        pop       = rd_pop && nonempty && !flush;
        push      = wr_valid && !flush && (!full || pop);
        drop      = wr_valid && !flush && full && !pop;
        count_nxt = flush ? '0 : count + CNT_W'(push) - CNT_W'(pop);
    end

    // Track the mode seen on the previous edge to detect a change
    always_ff @(posedge clk) begin
        en_q <= fifo_en;
    end

    // Advance pointers and fill state
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            nonempty <= 1'b0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
            count    <= count_nxt;
            nonempty <= (count_nxt != '0);
        end
    end

    // Sticky overrun: a dropped write sets it, a status read clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (drop) begin
            overrun <= 1'b1;
        end else if (lsr_rd) begin
            overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_trig.sv
// Module rxq_trig
// Receive-data interrupt: compares the fill count with the level picked
// by the selector in queued mode, follows data-ready otherwise.
// Assumes the level parameters do not exceed the queue depth.
module rxq_trig #(
    parameter int DEPTH   = 64,
    parameter int LEVEL_0 = 8,
    parameter int LEVEL_1 = 16,
    parameter int LEVEL_2 = 56,
    parameter int LEVEL_3 = 60,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic [CNT_W-1:0] count,
    input  logic             nonempty,
    output logic             irq
);
    logic [CNT_W-1:0] level;

    // Select the threshold and form the interrupt
    always_comb begin
        unique case (trig_sel)
            2'd0:    level = CNT_W'(LEVEL_0);
            2'd1:    level = CNT_W'(LEVEL_1);
            2'd2:    level = CNT_W'(LEVEL_2);
            default: level = CNT_W'(LEVEL_3);
        endcase
        irq = fifo_en ? (count >= level) : nonempty;
    end
endmodule

// File: rtl/rx_tag_fifo.sv
// Module rx_tag_fifo
// Receive queue of a serial channel keeping three error tags per character
// aligned with it, with trigger-level interrupt, fill count and overrun.
// Assumes DEPTH is at least 2; reset is synchronous, active low.
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int LEVEL_0 = 8,
    parameter int LEVEL_1 = 16,
    parameter int LEVEL_2 = 56,
    parameter int LEVEL_3 = 60,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic [1:0]        trig_sel,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_parity_err,
    input  logic              wr_frame_err,
    input  logic              wr_break,
    input  logic              rd_pop,
    input  logic              lsr_rd,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  lsr_tags,
    output logic              data_ready,
    output logic              rx_irq,
    output logic              overrun,
    output logic [CNT_W-1:0]  fill_count
);
    logic             push;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    rxq_entry_t       wr_entry;
    rxq_entry_t       head_entry;

    // Pack the character with its tags in line-status order
    assign wr_entry = '{data: wr_data, tags: {wr_break, wr_frame_err, wr_parity_err}};

    rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .wr_valid (wr_valid),
        .rd_pop   (rd_pop),
        .lsr_rd   (lsr_rd),
        .push     (push),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (fill_count),
        .nonempty (data_ready),
        .overrun  (overrun)
    );

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk        (clk),
        .push       (push),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .wr_entry   (wr_entry),
        .head_entry (head_entry)
    );

    rxq_trig #(
        .DEPTH   (DEPTH),
        .LEVEL_0 (LEVEL_0),
        .LEVEL_1 (LEVEL_1),
        .LEVEL_2 (LEVEL_2),
        .LEVEL_3 (LEVEL_3)
    ) trig_i (
        .fifo_en  (fifo_en),
        .trig_sel (trig_sel),
        .count    (fill_count),
        .nonempty (data_ready),
        .irq      (rx_irq)
    );

    // Expose the head entry
    assign head_data = head_entry.data;
    assign lsr_tags  = head_entry.tags;
endmodule

// File: rtl/rx_tag_fifo_chk.sv
// Module rx_tag_fifo_chk
// Port-level properties of rx_tag_fifo, attached by bind below.
// Assumes the same DEPTH and LEVEL_3 as the bound instance.
module rx_tag_fifo_chk #(
    parameter int DEPTH   = 64,
    parameter int LEVEL_3 = 60,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             wr_valid,
    input logic             rd_pop,
    input logic             lsr_rd,
    input logic             data_ready,
    input logic             rx_irq,
    input logic             overrun,
    input logic [CNT_W-1:0] fill_count
);
    assert_ready_tracks_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (fill_count != '0));

    assert_idle_holds_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !rd_pop && $stable(fifo_en)) |=> $stable(fill_count));

    assert_write_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $stable(fifo_en) && wr_valid && !rd_pop && fill_count < CNT_W'(DEPTH))
        |=> fill_count == $past(fill_count) + 1'b1);

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && $stable(fifo_en) && wr_valid && !rd_pop && fill_count == CNT_W'(DEPTH))
        |=> (overrun && fill_count == CNT_W'(DEPTH)));

    assert_status_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !wr_valid) |=> !overrun);

    assert_top_level_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && fill_count >= CNT_W'(LEVEL_3)) |-> rx_irq);

    assert_single_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_irq == data_ready));

    assert_single_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && $stable(fifo_en)) |-> fill_count <= CNT_W'(1));

    assert_mode_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fifo_en) |=> fill_count == '0);
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .LEVEL_3(LEVEL_3)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_en    (fifo_en),
    .wr_valid   (wr_valid),
    .rd_pop     (rd_pop),
    .lsr_rd     (lsr_rd),
    .data_ready (data_ready),
    .rx_irq     (rx_irq),
    .overrun    (overrun),
    .fill_count (fill_count)
);

// File: tb/rx_tag_fifo_tb_top.sv
// Bench for rx_tag_fifo: a vector table in queued mode, then directed
// tests for reset, trigger levels, full queue, overrun and mode switching.
module rx_tag_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic [1:0] trig_sel = 2'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_parity_err = 1'b0;
    logic       wr_frame_err = 1'b0;
    logic       wr_break = 1'b0;
    logic       rd_pop = 1'b0;
    logic       lsr_rd = 1'b0;
    logic [7:0] head_data;
    logic [2:0] lsr_tags;
    logic       data_ready;
    logic       rx_irq;
    logic       overrun;
    logic [6:0] fill_count;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    rx_tag_fifo dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_en       (fifo_en),
        .trig_sel      (trig_sel),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .wr_parity_err (wr_parity_err),
        .wr_frame_err  (wr_frame_err),
        .wr_break      (wr_break),
        .rd_pop        (rd_pop),
        .lsr_rd        (lsr_rd),
        .head_data     (head_data),
        .lsr_tags      (lsr_tags),
        .data_ready    (data_ready),
        .rx_irq        (rx_irq),
        .overrun       (overrun),
        .fill_count    (fill_count)
    );

    typedef struct packed {
        logic       wr;
        logic       pop;
        logic [7:0] data;
        logic [2:0] tags;
        logic [6:0] exp_cnt;
        logic [7:0] exp_head;
        logic [2:0] exp_tags;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 8'hA1, 3'b001, 7'd1, 8'hA1, 3'b001},
        '{1'b1, 1'b0, 8'hB2, 3'b010, 7'd2, 8'hA1, 3'b001},
        '{1'b1, 1'b0, 8'hC3, 3'b100, 7'd3, 8'hA1, 3'b001},
        '{1'b1, 1'b1, 8'hD4, 3'b011, 7'd3, 8'hB2, 3'b010},
        '{1'b0, 1'b1, 8'h00, 3'b000, 7'd2, 8'hC3, 3'b100},
        '{1'b0, 1'b1, 8'h00, 3'b000, 7'd1, 8'hD4, 3'b011},
        '{1'b0, 1'b1, 8'h00, 3'b000, 7'd0, 8'h00, 3'b000},
        '{1'b0, 1'b1, 8'h00, 3'b000, 7'd0, 8'h00, 3'b000},
        '{1'b1, 1'b1, 8'hE5, 3'b110, 7'd1, 8'hE5, 3'b110},
        '{1'b0, 1'b1, 8'h00, 3'b000, 7'd0, 8'h00, 3'b000}
    };

    // Compare one observed value with its expectation
    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one cycle from a negedge; returns at the next negedge, inputs idle
    task automatic cyc(input bit wr, input bit pop, input bit lrd,
                       input logic [7:0] d, input logic [2:0] t);
        wr_valid = wr; rd_pop = pop; lsr_rd = lrd; wr_data = d;
        {wr_break, wr_frame_err, wr_parity_err} = t;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0; rd_pop = 1'b0; lsr_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        // R1: reset state, with a write attempted during reset
        @(negedge clk);
        cyc(1'b1, 1'b0, 1'b0, 8'h55, 3'b111);
        check("R1 count in reset", fill_count, 0);
        check("R1 ready in reset", data_ready, 0);
        rst_n = 1'b1;
        check("R1 count", fill_count, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 overrun", overrun, 0);

        // R2 R3 R4 R5: vector table in queued mode
        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].wr, VECS[i].pop, 1'b0, VECS[i].data, VECS[i].tags);
            check("R4 table count", fill_count, VECS[i].exp_cnt);
            check("R5 table ready", data_ready, VECS[i].exp_cnt != 0);
            if (VECS[i].exp_cnt != 0) begin
                check("R2 table head", head_data, VECS[i].exp_head);
                check("R3 table tags", lsr_tags, VECS[i].exp_tags);
            end
        end

        // R6: each trigger level
        for (int k = 0; k < 64; k++) begin
            cyc(1'b1, 1'b0, 1'b0, 8'h40 + 8'(k), 3'b000);
            if (k == 6)  check("R6 below 8", rx_irq, 0);
            if (k == 7)  begin
                check("R6 at 8", rx_irq, 1);
                trig_sel = 2'd1; #1;
                check("R6 sel16 at 8", rx_irq, 0);
            end
            if (k == 14) check("R6 below 16", rx_irq, 0);
            if (k == 15) begin
                check("R6 at 16", rx_irq, 1);
                trig_sel = 2'd2; #1;
                check("R6 sel56 at 16", rx_irq, 0);
            end
            if (k == 54) check("R6 below 56", rx_irq, 0);
            if (k == 55) begin
                check("R6 at 56", rx_irq, 1);
                trig_sel = 2'd3; #1;
                check("R6 sel60 at 56", rx_irq, 0);
            end
            if (k == 58) check("R6 below 60", rx_irq, 0);
            if (k == 59) check("R6 at 60", rx_irq, 1);
        end
        check("R4 full count", fill_count, 64);

        // R7: dropped write at full
        cyc(1'b1, 1'b0, 1'b0, 8'hEE, 3'b111);
        check("R7 count stays", fill_count, 64);
        check("R7 overrun set", overrun, 1);
        check("R7 head unchanged", head_data, 8'h40);

        // R8: status read clears, then write+pop at full keeps it clear
        cyc(1'b0, 1'b0, 1'b1, 8'h00, 3'b000);
        check("R8 cleared", overrun, 0);
        cyc(1'b1, 1'b1, 1'b0, 8'h99, 3'b000);
        check("R7 write+pop count", fill_count, 64);
        check("R7 write+pop no overrun", overrun, 0);
        check("R2 head after pop", head_data, 8'h41);
        cyc(1'b1, 1'b0, 1'b1, 8'h77, 3'b000);
        check("R8 set wins", overrun, 1);
        cyc(1'b0, 1'b0, 1'b1, 8'h00, 3'b000);

        // R10: leaving queued mode flushes
        fifo_en = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 8'h12, 3'b000);
        check("R10 flush to single", fill_count, 0);

        // R9: single holding register
        trig_sel = 2'd3;
        cyc(1'b1, 1'b0, 1'b0, 8'h21, 3'b101);
        check("R9 one held", fill_count, 1);
        check("R9 irq follows ready", rx_irq, 1);
        check("R3 single tags", lsr_tags, 3'b101);
        cyc(1'b1, 1'b0, 1'b0, 8'h22, 3'b000);
        check("R9 second dropped count", fill_count, 1);
        check("R9 second dropped head", head_data, 8'h21);
        check("R9 overrun", overrun, 1);
        cyc(1'b0, 1'b1, 1'b0, 8'h00, 3'b000);
        check("R9 emptied", fill_count, 0);
        check("R9 irq low", rx_irq, 0);

        // R10: entering queued mode flushes
        cyc(1'b1, 1'b0, 1'b0, 8'h31, 3'b000);
        fifo_en = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 8'h00, 3'b000);
        check("R10 flush to queued", fill_count, 0);
        check("R5 ready after flush", data_ready, 0);

        finish_run();
    end
endmodule